// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block keeps a bank of hardware lock flags that two independent requesters, a left port and a right port, can both reach. Each port presents an index that selects one lock. A write whose data bit 0 is 0 asks for the lock, and a write whose data bit 0 is 1 gives it back. Every port can read the lock it currently indexes. The read result is all zeros when that port holds the lock and all ones otherwise.

A request that meets a lock held by the other side is not dropped. It is remembered as waiting. The moment the holder gives the lock back, it passes to the waiting side on the same clock edge, so the loser never has to poll and retry.

Each lock is a five-state machine:

- FREE: nobody holds the lock.
- L_OWN: the left port holds it.
- R_OWN: the right port holds it.
- L_OWN_RWAIT: the left port holds it and the right port is waiting.
- R_OWN_LWAIT: the right port holds it and the left port is waiting.

The named transitions are:

- grant: FREE to an owner state.
- tie-grant: FREE to L_OWN_RWAIT, when both ports ask in the same cycle.
- queue: an owner state to its waiting variant.
- handover: a waiting variant to the other owner state.
- cancel: a waiting variant back to the plain owner state.
- release: an owner state to FREE.
- pass-through: an owner state to the other owner, when the holder releases and the other port asks in the same cycle.

Top module: `sem_bank`

## Requirements
- R1: The bank holds NUM_SEM (default 8) locks, selected by each port's index input. A write changes only the lock whose number equals that port's index.
- R2: Only data bit 0 of a write is used: 0 means request and 1 means release. Bits 15:1 of the write data have no effect.
- R3: A port's read data is 16'h0000 when that port holds the indexed lock and 16'hFFFF otherwise. Both ports never read 16'h0000 for the same lock.
- R4: A request to a free lock makes the requesting port the owner on the next clock edge.
- R5: A request from the non-holding port to a held lock leaves ownership unchanged and records the request as waiting.
- R6: A release by the holder while the other port is waiting hands the lock to the waiting port on that same edge.
- R7: A release by the holder with nothing waiting makes the lock free, so both ports read 16'hFFFF.
- R8: A release from a port that neither holds the lock nor is waiting for it leaves the lock unchanged.
- R9: A release from a port whose own request is waiting cancels that request. If both ports release in the same cycle, the lock becomes free.
- R10: When both ports request a free lock in the same cycle, the left port is granted and the right request is recorded as waiting.
- R11: Reset (rst_n low) makes every lock free with nothing waiting.
- R12: A request from the current holder changes nothing. A holder release in the same cycle as a request from the other port passes the lock directly to the requester.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| l_wr | input | 1 | Left port write strobe |
| l_idx | input | 3 | Left port lock index (read and write) |
| l_wdata | input | 16 | Left port write data; bit 0 is the request value |
| l_rdata | output | 16 | Left port read status of the lock at l_idx |
| r_wr | input | 1 | Right port write strobe |
| r_idx | input | 3 | Right port lock index (read and write) |
| r_wdata | input | 16 | Right port write data; bit 0 is the request value |
| r_rdata | output | 16 | Right port read status of the lock at r_idx |

## Verification
The bench builds the bank with its default parameters: eight locks and a 16-bit data bus. With these values every lock index is reachable from both ports, and the full-width replication of the status can be checked bit for bit. Directed sequences walk every named transition, including the same-cycle collisions on one lock. A long stretch of random traffic is then confined to three locks so that collisions, handovers and cancels occur often, and it is compared against a behavioural model on every clock.

// File: rtl/sem_pkg.sv
package sem_pkg;

    typedef enum logic [2:0] {
        S_FREE      = 3'd0,
        S_L_OWN     = 3'd1,
        S_R_OWN     = 3'd2,
        S_L_OWN_RW  = 3'd3,
        S_R_OWN_LW  = 3'd4
    } sem_state_t;

endpackage

// File: rtl/sem_wr_decode.sv
module sem_wr_decode #(
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 16,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic               wr,
    input  logic [IDX_W-1:0]   idx,
    input  logic [DATA_W-1:0]  wdata,
    output logic [NUM_SEM-1:0] req,
    output logic [NUM_SEM-1:0] rel
);

    logic bit_val;

    always_comb begin
        bit_val = wdata[0];
    end

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_dec
        logic hit;
        always_comb begin
            hit    = wr && (idx == IDX_W'(g));
            req[g] = hit && !bit_val;
            rel[g] = hit &&  bit_val;
        end
    end

endmodule

// File: rtl/sem_cell.sv
module sem_cell
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_req,
    input  logic l_rel,
    input  logic r_req,
    input  logic r_rel,
    output logic l_owns,
    output logic r_owns
);

    sem_state_t state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_FREE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_FREE: begin
                if (l_req)      nxt = r_req ? S_L_OWN_RW : S_L_OWN;
                else if (r_req) nxt = S_R_OWN;
            end
            S_L_OWN: begin
                if (l_rel)      nxt = r_req ? S_R_OWN : S_FREE;
                else if (r_req) nxt = S_L_OWN_RW;
            end
            S_R_OWN: begin
                if (r_rel)      nxt = l_req ? S_L_OWN : S_FREE;
                else if (l_req) nxt = S_R_OWN_LW;
            end
            S_L_OWN_RW: begin
                if (l_rel)      nxt = r_rel ? S_FREE : S_R_OWN;
                else if (r_rel) nxt = S_L_OWN;
            end
            S_R_OWN_LW: begin
                if (r_rel)      nxt = l_rel ? S_FREE : S_L_OWN;
                else if (l_rel) nxt = S_R_OWN;
            end
            default: nxt = S_FREE;
        endcase
    end

    always_comb begin
        l_owns = 1'b0;
        r_owns = 1'b0;
        unique case (state)
            S_L_OWN, S_L_OWN_RW: l_owns = 1'b1;
            S_R_OWN, S_R_OWN_LW: r_owns = 1'b1;
            default: ;
        endcase
    end

    // R10
    tie_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FREE && l_req && r_req) |=> (state == S_L_OWN_RW));

    // R6
    handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_L_OWN_RW && l_rel && !r_rel) |=> (r_owns && !l_owns));

    // R5
    queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_R_OWN && l_req && !r_rel) |=> (state == S_R_OWN_LW));

    // R8
    stranger_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_L_OWN && r_rel && !l_rel) |=> $stable(state));

    // R3
    one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_owns && r_owns));

endmodule

// File: rtl/sem_rd_mux.sv
module sem_rd_mux #(
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 16,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic [NUM_SEM-1:0] owns,
    input  logic [IDX_W-1:0]   idx,
    output logic [DATA_W-1:0]  rdata
);

    logic held;

    always_comb begin
        held  = owns[idx];
        rdata = {DATA_W{!held}};
    end

endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 16,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_wr,
    input  logic [IDX_W-1:0]  l_idx,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_wr,
    input  logic [IDX_W-1:0]  r_idx,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);

    logic [NUM_SEM-1:0] l_req, l_rel, r_req, r_rel;
    logic [NUM_SEM-1:0] l_owns, r_owns;

    sem_wr_decode #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_ldec (
        .wr(l_wr), .idx(l_idx), .wdata(l_wdata), .req(l_req), .rel(l_rel)
    );

    sem_wr_decode #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rdec (
        .wr(r_wr), .idx(r_idx), .wdata(r_wdata), .req(r_req), .rel(r_rel)
    );

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_sem
        sem_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .l_req  (l_req[g]),
            .l_rel  (l_rel[g]),
            .r_req  (r_req[g]),
            .r_rel  (r_rel[g]),
            .l_owns (l_owns[g]),
            .r_owns (r_owns[g])
        );
    end

    sem_rd_mux #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_lmux (
        .owns(l_owns), .idx(l_idx), .rdata(l_rdata)
    );

    sem_rd_mux #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rmux (
        .owns(r_owns), .idx(r_idx), .rdata(r_rdata)
    );

    // R3
    exclusive_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_idx == r_idx) |-> (l_rdata[0] || r_rdata[0]));

    // R3
    replicate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((l_rdata == '0) || (l_rdata == '1)) && ((r_rdata == '0) || (r_rdata == '1)));

    // R11
    reset_free_chk: assert property (@(posedge clk)
        !rst_n |=> (l_owns == '0 && r_owns == '0));

endmodule

// File: tb/tb_sem_bank.sv
module tb_sem_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        l_wr = 1'b0, r_wr = 1'b0;
    logic [2:0]  l_idx = '0, r_idx = '0;
    logic [15:0] l_wdata = '0, r_wdata = '0;
    logic [15:0] l_rdata, r_rdata;

    int total = 0;
    int bad = 0;
    int owner [NS];   // 0 none, 1 left, 2 right
    int waiting [NS]; // 1 when the non-owner has a queued request
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sem_bank dut (
        .clk(clk), .rst_n(rst_n),
        .l_wr(l_wr), .l_idx(l_idx), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_wr(r_wr), .r_idx(r_idx), .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    task automatic model_release(int s, int who);
        if (owner[s] == who) begin
            if (waiting[s] != 0) begin
                owner[s] = 3 - who;
                waiting[s] = 0;
            end else begin
                owner[s] = 0;
            end
        end else if (owner[s] != 0 && waiting[s] != 0) begin
            waiting[s] = 0;
        end
    endtask

    task automatic model_request(int s, int who);
        if (owner[s] == 0) owner[s] = who;
        else if (owner[s] != who) waiting[s] = 1;
    endtask

    task automatic model_step(bit lw, int li, bit lv, bit rw, int ri, bit rv);
        if (lw && lv) model_release(li, 1);
        if (rw && rv) model_release(ri, 2);
        if (lw && !lv) model_request(li, 1);
        if (rw && !rv) model_request(ri, 2);
    endtask

    task automatic check_reads(string tag);
        logic [15:0] el, er;
        el = (owner[l_idx] == 1) ? 16'h0000 : 16'hFFFF;
        er = (owner[r_idx] == 2) ? 16'h0000 : 16'hFFFF;
        total++;
        if (l_rdata !== el) begin
            bad++;
            $display("FAIL %s left idx=%0d actual=%h expected=%h", tag, l_idx, l_rdata, el);
        end
        total++;
        if (r_rdata !== er) begin
            bad++;
            $display("FAIL %s right idx=%0d actual=%h expected=%h", tag, r_idx, r_rdata, er);
        end
    endtask

    // Drive at negedge, model follows the posedge, compare at the next negedge.
    task automatic cyc(bit lw, int li, logic [15:0] ld, bit rw, int ri, logic [15:0] rd, string tag);
        l_wr = lw; l_idx = 3'(li); l_wdata = ld;
        r_wr = rw; r_idx = 3'(ri); r_wdata = rd;
        @(posedge clk);
        model_step(lw, li, ld[0], rw, ri, rd[0]);
        @(negedge clk);
        check_reads(tag);
    endtask

    task automatic sweep(string tag);
        for (int s = 0; s < NS; s++) cyc(0, s, 16'h0, 0, NS-1-s, 16'h0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < NS; s++) begin owner[s] = 0; waiting[s] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        sweep("R11");

        // R4 grant, R12 owner re-request, R5 queue, R8 stranger
        cyc(1, 2, 16'h0000, 0, 2, 16'h0, "R4");
        cyc(1, 2, 16'h0000, 0, 2, 16'h0, "R12");
        cyc(0, 2, 16'h0, 1, 2, 16'h0000, "R5");
        // R6 handover
        cyc(1, 2, 16'h0001, 0, 2, 16'h0, "R6");
        // R7 release to free
        cyc(0, 2, 16'h0, 1, 2, 16'h0001, "R7");
        // R8 stranger release on owned lock
        cyc(1, 5, 16'h0000, 0, 5, 16'h0, "R4");
        cyc(0, 5, 16'h0, 1, 5, 16'h0001, "R8");
        // R9 cancel waiting
        cyc(0, 5, 16'h0, 1, 5, 16'h0000, "R5");
        cyc(0, 5, 16'h0, 1, 5, 16'h0001, "R9");
        cyc(1, 5, 16'h0001, 0, 5, 16'h0, "R9");
        // R10 tie on free lock, then both release together
        cyc(1, 7, 16'h0000, 1, 7, 16'h0000, "R10");
        cyc(1, 7, 16'h0001, 1, 7, 16'h0001, "R9");
        // R12 pass-through: holder releases while other requests
        cyc(0, 0, 16'h0, 1, 0, 16'h0000, "R4");
        cyc(1, 0, 16'h0000, 1, 0, 16'h0001, "R12");
        // R2 upper bits ignored
        cyc(0, 1, 16'h0, 1, 1, 16'hFFFE, "R2");
        cyc(0, 1, 16'h0, 1, 1, 16'h0001, "R2");
        cyc(1, 3, 16'h8000, 0, 3, 16'h0, "R2");
        // R1 independence across locks
        sweep("R1");
        cyc(1, 3, 16'h0001, 1, 0, 16'h0001, "R1");
        cyc(1, 0, 16'h0001, 0, 0, 16'h0, "R1");
        sweep("R3");

        // Random traffic on three locks to force collisions
        for (int n = 0; n < 3000; n++) begin
            cyc(bit'($urandom_range(0, 1)), $urandom_range(0, 2), 16'($urandom),
                bit'($urandom_range(0, 1)), $urandom_range(0, 2), 16'($urandom), "R6");
        end
        sweep("R1");

        // Reset mid-run
        rst_n = 1'b0;
        @(posedge clk);
        for (int s = 0; s < NS; s++) begin owner[s] = 0; waiting[s] = 0; end
        @(negedge clk);
        rst_n = 1'b1;
        sweep("R11");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule